// File: doc/BRIEF.md
# Thermal Alert Controller with Fault Queue

This block turns a stream of 12-bit temperature results into an alert line. Each time the converter signals a finished conversion, the result is compared as a signed number against a programmable high limit and a programmable low limit. A consecutive-fault counter filters noise: the alert state only changes once a selectable number of back-to-back conversions all meet the condition currently being watched. Any conversion that misses the condition restarts the count.

Two alert behaviours are offered. In comparator mode the alert is a level with hysteresis: it turns on above the high limit and turns off again only below the low limit. In interrupt mode the alert is an event: it latches on when a limit trips and stays on until software reads any register, the device wins an alert-response arbitration, or shutdown is entered. Each clear hands the watch over to the other limit, so high and low events alternate. A status bit records which limit caused the alert, for the alert-response reply. Limit and configuration storage, and the bus decoding that produces the read, arbitration and register-reset pulses, live in neighbouring blocks.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: The queue select `fq_sel` sets how many consecutive qualifying conversions change the alert state: 00 needs 1, 01 needs 2, 10 needs 4, 11 needs 6. Only cycles with `conv_done` high count, and a conversion that fails the watched condition restarts the count from zero.
- R2: In comparator mode (`int_mode` = 0), while the alert is off, the watched condition is result greater than or equal to `lim_hi`; reaching the queue depth turns the alert on at the clock edge that samples the last qualifying `conv_done`.
- R3: In comparator mode, while the alert is on, the watched condition is result strictly below `lim_lo`; reaching the queue depth turns it off. `reg_read`, `ara_win` and `shutdown` have no effect on the alert in this mode.
- R4: In interrupt mode (`int_mode` = 1) the alert turns on after the queue depth of results at or above `lim_hi`, and stays on, ignoring further conversions, until a cycle with `reg_read`, `ara_win` or `shutdown` high clears it. A clear and a `conv_done` in the same cycle: the clear wins and that conversion is dropped.
- R5: After an interrupt-mode clear the watched condition becomes result below `lim_lo`; that alert is cleared the same way and the watch then returns to the high limit.
- R6: `alert_pin` is registered: with `pol` = 0 it is the inverse of `alert_active` (active low), with `pol` = 1 it equals `alert_active`; a change of `pol` shows on the pin one clock later.
- R7: Comparisons treat result and limits as two's-complement numbers and use all 12 bits (0xFFC, -0.25 degrees, is below a low limit of 0x4B0 and below a high limit of 0x500).
- R8: `alert_cause` is 1 when the alert was raised by the high limit and 0 when raised by the low limit; in comparator mode turning off sets it to 0. It is 0 after reset.
- R9: `rst` or a `gc_reset` pulse clears the alert (pin at its inactive level), the fault count and the cause, and points the interrupt watch at the high limit, one clock later.
- R10: A change of `int_mode` or `fq_sel` clears the fault count and points the interrupt watch at the high limit; it also clears the alert when `int_mode` changed or the block is in interrupt mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a new result is valid |
| temp_result | input | 12 | Signed conversion result |
| lim_hi | input | 12 | Signed high limit |
| lim_lo | input | 12 | Signed low limit |
| fq_sel | input | 2 | Fault queue depth select |
| pol | input | 1 | Pin polarity: 1 active high, 0 active low |
| int_mode | input | 1 | 0 comparator mode, 1 interrupt mode |
| reg_read | input | 1 | Pulse: any register was read |
| ara_win | input | 1 | Pulse: alert-response arbitration won |
| shutdown | input | 1 | Shutdown mode is in effect |
| gc_reset | input | 1 | Pulse: register reset request from the bus |
| alert_pin | output | 1 | Alert output level after polarity |
| alert_active | output | 1 | Alert state, active high |
| alert_cause | output | 1 | 1 high-limit cause, 0 low-limit cause |

## Verification
The bench walks a result sequence that sits exactly on the high limit, one code under it, exactly on the low limit and one code under it, so a design using strict greater-than at the top or less-or-equal at the bottom turns the alert on or off one conversion late or early. Negative codes close to zero are fed in so that an unsigned compare would treat them as very hot and raise a false alert. Interrupted fault runs, a queue-depth change in the middle of a count and a clear landing on the same cycle as a conversion catch designs that keep stale counts, skip the hand-over between limits, or re-trigger from a dropped sample. Read, arbitration and shutdown pulses are applied in comparator mode, where a design that wrongly honours them drops a live alert.

// File: rtl/tac_pkg.sv
`timescale 1ns/1ps
package tac_pkg;
  // deepest selectable queue and the counter width that can hold it
  localparam int MAX_QUEUE = 6;
  localparam int QCNT_W    = $clog2(MAX_QUEUE + 1);

  // depth of the consecutive-fault queue for each select code
  function automatic logic [QCNT_W-1:0] queue_depth(input logic [1:0] sel);
    logic [QCNT_W-1:0] d;
    case (sel)
      2'b00:   d = QCNT_W'(1);
      2'b01:   d = QCNT_W'(2);
      2'b10:   d = QCNT_W'(4);
      default: d = QCNT_W'(MAX_QUEUE);
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tac_compare.sv
`timescale 1ns/1ps
module tac_compare #(
  parameter int TEMP_W = 12
) (
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] hi,
  input  logic [TEMP_W-1:0] lo,
  output logic              at_or_above_hi,
  output logic              below_lo
);
  // full-width two's-complement compare, independent of converter resolution
  always_comb begin
    at_or_above_hi = ($signed(temp) >= $signed(hi));
    below_lo       = ($signed(temp) <  $signed(lo));
  end
endmodule

// File: rtl/tac_fault_queue.sv
`timescale 1ns/1ps
module tac_fault_queue #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             cond,
  input  logic [CNT_W-1:0] need,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt + 1'b1;
    hit     = step && cond && (cnt_inc >= need);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (step) begin
      if (cond && !hit) cnt <= cnt_inc;
      else              cnt <= '0;
    end
  end

  // R1: the run length never reaches the queue depth without firing
  assert_cnt_below_need_R1: assert property (@(posedge clk) disable iff (rst || clr)
    cnt < need);
  // R1: a fired queue starts the next run from zero
  assert_restart_after_hit_R1: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt == '0));
endmodule

// File: rtl/tac_alert_state.sv
`timescale 1ns/1ps
module tac_alert_state (
  input  logic clk,
  input  logic rst,
  input  logic gc_reset,
  input  logic int_mode,
  input  logic cfg_chg,
  input  logic mode_chg,
  input  logic pol,
  input  logic hit,
  input  logic ack_evt,
  output logic active,
  output logic phase_hi,
  output logic cause,
  output logic pin
);
  logic active_n, phase_n, cause_n;

  always_comb begin
    active_n = active;
    phase_n  = phase_hi;
    cause_n  = cause;
    if (rst || gc_reset) begin
      active_n = 1'b0;
      phase_n  = 1'b1;
      cause_n  = 1'b0;
    end else if (cfg_chg) begin
      phase_n = 1'b1;
      if (mode_chg || int_mode) active_n = 1'b0;
    end else if (int_mode && active && ack_evt) begin
      active_n = 1'b0;
      phase_n  = ~phase_hi;
    end else if (hit) begin
      if (int_mode) begin
        active_n = 1'b1;
        cause_n  = phase_hi;
      end else begin
        active_n = ~active;
        cause_n  = ~active;
      end
    end
  end

  always_ff @(posedge clk) begin
    active   <= active_n;
    phase_hi <= phase_n;
    cause    <= cause_n;
    pin      <= ~(active_n ^ pol);
  end

  // R4: an acknowledge in interrupt mode drops a live alert
  assert_int_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (int_mode && active && ack_evt && !gc_reset && !cfg_chg) |=> !active);
  // R3: acknowledges leave a comparator-mode alert alone
  assert_cmp_ignores_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (!int_mode && ack_evt && !hit && !gc_reset && !cfg_chg) |=> $stable(active));
  // R9: register reset clears the alert and re-arms the high watch
  assert_gc_clears_R9: assert property (@(posedge clk) disable iff (rst)
    gc_reset |=> (!active && phase_hi));
  // R8: an interrupt alert reports the limit that was being watched
  assert_cause_matches_R8: assert property (@(posedge clk) disable iff (rst)
    (int_mode && $rose(active)) |-> (cause == $past(phase_hi)));
endmodule

// File: rtl/thermal_alert_ctrl.sv
`timescale 1ns/1ps
module thermal_alert_ctrl #(
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [TEMP_W-1:0] temp_result,
  input  logic [TEMP_W-1:0] lim_hi,
  input  logic [TEMP_W-1:0] lim_lo,
  input  logic [1:0]        fq_sel,
  input  logic              pol,
  input  logic              int_mode,
  input  logic              reg_read,
  input  logic              ara_win,
  input  logic              shutdown,
  input  logic              gc_reset,
  output logic              alert_pin,
  output logic              alert_active,
  output logic              alert_cause
);
  import tac_pkg::*;

  localparam int CFG_W = 3;

  logic [CFG_W-1:0]  cfg_now, cfg_q;
  logic              cfg_chg, mode_chg;
  logic              ge_hi, lt_lo;
  logic              watch_hi, cond, step, hit, ack_evt, q_clr;
  logic              active, phase_hi, cause, pin;
  logic [QCNT_W-1:0] need;

  assign cfg_now = {int_mode, fq_sel};

  always_ff @(posedge clk) begin
    cfg_q <= cfg_now;
  end

  always_comb begin
    cfg_chg  = (cfg_now != cfg_q);
    mode_chg = (int_mode != cfg_q[CFG_W-1]);
    need     = queue_depth(fq_sel);
    ack_evt  = reg_read || ara_win || shutdown;
    watch_hi = int_mode ? phase_hi : ~active;
    cond     = watch_hi ? ge_hi : lt_lo;
    step     = conv_done && !(int_mode && active);
    q_clr    = gc_reset || cfg_chg || (int_mode && active && ack_evt);
  end

  tac_compare #(.TEMP_W(TEMP_W)) u_cmp (
    .temp           (temp_result),
    .hi             (lim_hi),
    .lo             (lim_lo),
    .at_or_above_hi (ge_hi),
    .below_lo       (lt_lo)
  );

  tac_fault_queue #(.CNT_W(QCNT_W)) u_queue (
    .clk  (clk),
    .rst  (rst),
    .clr  (q_clr),
    .step (step),
    .cond (cond),
    .need (need),
    .hit  (hit)
  );

  tac_alert_state u_state (
    .clk      (clk),
    .rst      (rst),
    .gc_reset (gc_reset),
    .int_mode (int_mode),
    .cfg_chg  (cfg_chg),
    .mode_chg (mode_chg),
    .pol      (pol),
    .hit      (hit),
    .ack_evt  (ack_evt),
    .active   (active),
    .phase_hi (phase_hi),
    .cause    (cause),
    .pin      (pin)
  );

  assign alert_pin    = pin;
  assign alert_active = active;
  assign alert_cause  = cause;

  // R2: the alert only switches on at an edge that sampled a conversion
  assert_rise_on_conv_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_active) |-> $past(conv_done));
  // R6: pin level follows the alert through the polarity seen at the last edge
  assert_pin_polarity_R6: assert property (@(posedge clk) disable iff (rst)
    alert_pin == (alert_active == $past(pol)));
  // R10: a mode switch always leaves the alert off
  assert_mode_switch_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_chg && !rst) |=> !alert_active);
endmodule

// File: tb/tb_thermal_alert_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_alert_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_done = 1'b0;
  logic [11:0] temp_result = '0;
  logic [11:0] lim_hi = 12'h500;
  logic [11:0] lim_lo = 12'h4B0;
  logic [1:0]  fq_sel = 2'b01;
  logic        pol = 1'b0;
  logic        int_mode = 1'b0;
  logic        reg_read = 1'b0;
  logic        ara_win = 1'b0;
  logic        shutdown = 1'b0;
  logic        gc_reset = 1'b0;
  logic        alert_pin, alert_active, alert_cause;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  thermal_alert_ctrl dut (
    .clk(clk), .rst(rst), .conv_done(conv_done), .temp_result(temp_result),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .fq_sel(fq_sel), .pol(pol),
    .int_mode(int_mode), .reg_read(reg_read), .ara_win(ara_win),
    .shutdown(shutdown), .gc_reset(gc_reset), .alert_pin(alert_pin),
    .alert_active(alert_active), .alert_cause(alert_cause)
  );

  // {expected cause, expected active, result}; comparator mode, depth 2
  localparam logic [13:0] VEC [10] = '{
    {2'b00, 12'h500},   // at high: run 1
    {2'b00, 12'h4FF},   // one below high: run restarts
    {2'b00, 12'h500},   // run 1
    {2'b11, 12'h7FF},   // run 2: on, high cause
    {2'b11, 12'h4AF},   // below low: run 1
    {2'b11, 12'h4B0},   // equal to low: restart
    {2'b11, 12'h4AF},   // run 1
    {2'b00, 12'hE70},   // negative, run 2: off
    {2'b00, 12'h7FF},   // run 1
    {2'b00, 12'hFFC}    // -0.25, restart
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic conv(input logic [11:0] v);
    @(negedge clk);
    conv_done = 1'b1;
    temp_result = v;
    @(posedge clk); #1;
    conv_done = 1'b0;
  endtask

  task automatic set_cfg(input logic tm, input logic [1:0] fq);
    @(negedge clk);
    int_mode = tm;
    fq_sel = fq;
    @(posedge clk); #1;
  endtask

  task automatic gc_pulse();
    @(negedge clk);
    gc_reset = 1'b1;
    @(posedge clk); #1;
    gc_reset = 1'b0;
  endtask

  task automatic ack_pulse(input int kind);
    @(negedge clk);
    if (kind == 0) reg_read = 1'b1;
    else if (kind == 1) ara_win = 1'b1;
    else shutdown = 1'b1;
    @(posedge clk); #1;
    reg_read = 1'b0; ara_win = 1'b0; shutdown = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R9 reset active", alert_active, 0);
    chk("R6 reset pin inactive high", alert_pin, 1);
    chk("R8 reset cause", alert_cause, 0);

    // comparator table: R2 R3 R7
    for (int i = 0; i < 10; i++) begin
      conv(VEC[i][11:0]);
      chk($sformatf("R2 R3 R7 vec %0d active", i), alert_active, VEC[i][12]);
      chk($sformatf("R8 vec %0d cause", i), alert_cause, VEC[i][13]);
      chk($sformatf("R6 vec %0d pin", i), alert_pin, !VEC[i][12]);
    end

    // R1: depth 6
    set_cfg(1'b0, 2'b11);
    for (int i = 0; i < 5; i++) conv(12'h500);
    chk("R1 depth6 after five", alert_active, 0);
    conv(12'h500);
    chk("R1 depth6 after six", alert_active, 1);

    // R3: acknowledges ignored in comparator mode
    ack_pulse(0); ack_pulse(1); ack_pulse(2);
    chk("R3 comparator ignores ack", alert_active, 1);

    // R6: polarity
    @(negedge clk); pol = 1'b1; @(posedge clk); #1;
    chk("R6 active high pin", alert_pin, 1);
    @(negedge clk); pol = 1'b0; @(posedge clk); #1;
    chk("R6 active low pin", alert_pin, 0);

    // R9: register reset
    gc_pulse();
    chk("R9 gc clears", alert_active, 0);
    chk("R9 gc pin", alert_pin, 1);

    // R1: depth 4 with broken run
    set_cfg(1'b0, 2'b10);
    for (int i = 0; i < 3; i++) conv(12'h500);
    conv(12'h000);
    for (int i = 0; i < 3; i++) conv(12'h500);
    chk("R1 depth4 restart", alert_active, 0);
    conv(12'h500);
    chk("R1 depth4 fires", alert_active, 1);

    // R10: depth change clears a partial count
    gc_pulse();
    set_cfg(1'b0, 2'b01);
    conv(12'h500);
    set_cfg(1'b0, 2'b10);
    for (int i = 0; i < 3; i++) conv(12'h500);
    chk("R10 count cleared on depth change", alert_active, 0);
    conv(12'h500);
    chk("R10 fires at new depth", alert_active, 1);

    // interrupt mode, depth 1
    gc_pulse();
    set_cfg(1'b1, 2'b00);
    chk("R10 mode change clears", alert_active, 0);
    conv(12'h500);
    chk("R4 int on at high", alert_active, 1);
    chk("R8 int high cause", alert_cause, 1);
    conv(12'h100);
    chk("R4 conversions ignored while on", alert_active, 1);
    ack_pulse(0);
    chk("R4 read clears", alert_active, 0);
    conv(12'h600);
    chk("R5 high not watched after clear", alert_active, 0);
    conv(12'h100);
    chk("R5 low trips", alert_active, 1);
    chk("R8 low cause", alert_cause, 0);
    ack_pulse(1);
    chk("R4 arbitration win clears", alert_active, 0);
    conv(12'h100);
    chk("R5 low not watched after second clear", alert_active, 0);
    conv(12'h500);
    chk("R5 high watched again", alert_active, 1);
    ack_pulse(2);
    chk("R4 shutdown clears", alert_active, 0);
    conv(12'h100);
    chk("R5 low alert again", alert_active, 1);
    // clear and conversion in the same cycle
    @(negedge clk);
    reg_read = 1'b1; conv_done = 1'b1; temp_result = 12'h500;
    @(posedge clk); #1;
    reg_read = 1'b0; conv_done = 1'b0;
    chk("R4 clear wins over same-cycle conversion", alert_active, 0);
    conv(12'h500);
    chk("R4 next conversion trips high", alert_active, 1);
    chk("R8 cause high after hand-over", alert_cause, 1);

    // R10: mode switch drops an interrupt alert
    set_cfg(1'b0, 2'b00);
    chk("R10 mode switch clears alert", alert_active, 0);
    chk("R6 pin after mode switch", alert_pin, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule